// File: doc/BRIEF.md
# Entropy Seeded Pseudo-Random Byte Source

This block turns a slow 2-bit entropy stream into a 16-bit seed and loads it into a 16-bit linear feedback shift register. The register then hands out pseudo-random bytes on demand. A start pulse powers up the entropy source and waits until that source reports that it has settled. Each 2-bit sample is then folded into the seed by a shift of two places followed by an XOR. Collection runs for at least a minimum number of samples. It keeps going while the seed sits on one of two forbidden values.

The finished seed goes into the generator through a single byte-wide load path, in two cycles, high byte first. After that the entropy source is switched off. The block then serves requests. A step pulse advances the generator by one clock. Up to two byte reads follow each step: the first read returns the low byte and the second returns the high byte. A caller that needs an odd number of bytes simply steps again after a single read.

Top module: `ent_lfsr_rng`

## Requirements
- R1: While reset is held and in the cycle after it, busy is 1, the source enable is 0 and the read data is 0x00.
- R2: A start pulse raises the source enable in the next cycle. Sample strobes are ignored until the source-valid input has been seen high.
- R3: Each accepted sample updates the seed as seed = (seed << 2) XOR sample, with the sample placed in bits 1:0.
- R4: The block accepts at least MIN_SAMPLES (8) samples before it loads any seed. The sample count saturates and does not wrap.
- R5: A seed equal to 0x0000 or 0x8003 is never loaded. Collection continues with further samples until the seed differs from both.
- R6: The seed enters the generator high byte first, then low byte. The generator holds exactly the seed when busy falls.
- R7: Busy is 0 only in the ready state. The source enable is 0 whenever busy is 0.
- R8: A step pulse in the ready state advances the state once: s' = (s >> 1) XOR (s[0] ? 0xA001 : 0), which is the x^16+x^15+x^2+1 Galois form. A zero result is replaced by 0x0001. Without a step the state holds.
- R9: In the ready state, a read with no step in the same cycle puts a byte on the read data in the next cycle. After a step the first read returns bits 7:0 and the second returns bits 15:8. A step returns the byte order to the low byte, so reading an odd count yields only the low byte of the last step. Reads outside the ready state, and reads in the same cycle as a step, leave the read data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin seeding, taken only when idle |
| src_en_o | output | 1 | Power enable for the entropy source |
| src_valid_i | input | 1 | Entropy source has settled |
| samp_i | input | 2 | Entropy sample |
| samp_stb_i | input | 1 | Sample strobe |
| step_i | input | 1 | Advance the generator one clock |
| rd_i | input | 1 | Byte read request |
| rd_data_o | output | 8 | Byte returned by the last read |
| busy_o | output | 1 | High in every state but ready |

## Verification
The bench uses the default widths of a 16-bit seed and generator, 2-bit samples and a minimum of eight samples. With these values the seed and every stepped state can be worked out by hand. The sample patterns are chosen so that the eighth sample lands exactly on 0x0000 and, in another run, on 0x8003. This drives the rejection path and the saturated counter into extra samples. A run with samples sent before source-valid confirms that they leave no trace in the loaded seed.

// File: rtl/ent_lfsr_rng.sv
module ent_lfsr_rng #(
  parameter int          W           = 16,
  parameter int          SW          = 2,
  parameter int          MIN_SAMPLES = 8,
  parameter logic [15:0] TAPS        = 16'hA001,
  parameter logic [15:0] BAD_A       = 16'h0000,
  parameter logic [15:0] BAD_B       = 16'h8003
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  output logic          src_en_o,
  input  logic          src_valid_i,
  input  logic [SW-1:0] samp_i,
  input  logic          samp_stb_i,
  input  logic          step_i,
  input  logic          rd_i,
  output logic [7:0]    rd_data_o,
  output logic          busy_o
);
  localparam int CW = $clog2(MIN_SAMPLES + 1);
  localparam logic [CW-1:0] CMAX = CW'(MIN_SAMPLES);

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_COLLECT, S_LD_HI, S_LD_LO, S_READY
  } st_t;

  st_t           state_q;
  logic [W-1:0]  seed_q, lfsr_q;
  logic [CW-1:0] cnt_q;
  logic          hi_q;

  wire [W-1:0]  seed_nx = {seed_q[W-SW-1:0], {SW{1'b0}}} ^ {{(W-SW){1'b0}}, samp_i};
  wire [CW-1:0] cnt_nx  = (cnt_q == CMAX) ? cnt_q : cnt_q + 1'b1;
  wire          seed_ok = (cnt_nx == CMAX) && (seed_nx != BAD_A) && (seed_nx != BAD_B);
  wire [W-1:0]  gal     = {1'b0, lfsr_q[W-1:1]} ^ (lfsr_q[0] ? TAPS : '0);
  wire [W-1:0]  lfsr_nx = (gal == '0) ? W'(1) : gal;

  wire       ld_we   = (state_q == S_LD_HI) || (state_q == S_LD_LO);
  wire       ld_hi   = (state_q == S_LD_HI);
  wire [7:0] ld_byte = ld_hi ? seed_q[15:8] : seed_q[7:0];

  assign busy_o   = (state_q != S_READY);
  assign src_en_o = (state_q != S_READY) && (state_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= S_IDLE;
      seed_q    <= '0;
      cnt_q     <= '0;
      lfsr_q    <= W'(1);
      hi_q      <= 1'b0;
      rd_data_o <= 8'h00;
    end else begin
      case (state_q)
        S_IDLE:    if (start_i) state_q <= S_WAIT;
        S_WAIT:    if (src_valid_i) state_q <= S_COLLECT;
        S_COLLECT: if (samp_stb_i) begin
          seed_q <= seed_nx;
          cnt_q  <= cnt_nx;
          if (seed_ok) state_q <= S_LD_HI;
        end
        S_LD_HI:   state_q <= S_LD_LO;
        S_LD_LO:   state_q <= S_READY;
        S_READY: begin
          if (step_i) begin
            lfsr_q <= lfsr_nx;
            hi_q   <= 1'b0;
          end else if (rd_i) begin
            rd_data_o <= hi_q ? lfsr_q[15:8] : lfsr_q[7:0];
            hi_q      <= ~hi_q;
          end
        end
        default:   state_q <= S_IDLE;
      endcase
      if (ld_we) begin
        if (ld_hi) lfsr_q[15:8] <= ld_byte;
        else       lfsr_q[7:0]  <= ld_byte;
      end
    end
  end
endmodule

// File: rtl/ent_lfsr_rng_chk.sv
module ent_lfsr_rng_chk #(
  parameter int W  = 16,
  parameter int CW = 4,
  parameter int MIN_SAMPLES = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          busy_o,
  input logic          src_en_o,
  input logic          step_i,
  input logic [7:0]    rd_data_o,
  input logic [W-1:0]  lfsr_q,
  input logic [W-1:0]  seed_q,
  input logic [CW-1:0] cnt_q
);
  p_en_off_ready_r7: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !src_en_o);
  p_cnt_sat_r4: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) <= MIN_SAMPLES);
  p_lfsr_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    lfsr_q != '0);
  p_hold_no_step_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !step_i) |=> $stable(lfsr_q));
  p_load_matches_seed_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (lfsr_q == seed_q));
  p_no_bad_seed_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_o) |-> (seed_q != 16'h0000 && seed_q != 16'h8003));
  p_no_read_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(rd_data_o));
endmodule

bind ent_lfsr_rng ent_lfsr_rng_chk #(.W(W), .CW(CW), .MIN_SAMPLES(MIN_SAMPLES)) chk_i (
  .clk(clk), .rst(rst), .busy_o(busy_o), .src_en_o(src_en_o), .step_i(step_i),
  .rd_data_o(rd_data_o), .lfsr_q(lfsr_q), .seed_q(seed_q), .cnt_q(cnt_q)
);

// File: tb/ent_lfsr_rng_tb_top.sv
`timescale 1ns/1ps
module ent_lfsr_rng_tb_top;
  logic clk = 0, rst = 1, start = 0, valid = 0, stb = 0, step = 0, rd = 0;
  logic [1:0] samp = 0;
  logic [7:0] rdata;
  logic en, busy;
  int checks = 0, fails = 0, cyc = 0;
  bit cmp_on = 0;

  always #4 clk = ~clk;

  ent_lfsr_rng dut_i (.clk(clk), .rst(rst), .start_i(start), .src_en_o(en),
    .src_valid_i(valid), .samp_i(samp), .samp_stb_i(stb), .step_i(step),
    .rd_i(rd), .rd_data_o(rdata), .busy_o(busy));

  int m_ph = 0, m_seed = 0, m_cnt = 0, m_gen = 1, m_data = 0, m_hi = 0;

  function automatic int adv(int s);
    int r = (s >> 1) ^ ((s & 1) ? 'hA001 : 0);
    return (r == 0) ? 1 : r;
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ph = 0; m_seed = 0; m_cnt = 0; m_gen = 1; m_data = 0; m_hi = 0;
    end else begin
      case (m_ph)
        0: if (start) m_ph = 1;
        1: if (valid) m_ph = 2;
        2: if (stb) begin
          m_seed = ((m_seed << 2) ^ samp) & 'hFFFF;
          if (m_cnt < 8) m_cnt++;
          if (m_cnt >= 8 && m_seed != 0 && m_seed != 'h8003) m_ph = 3;
        end
        3: m_ph = 4;
        4: begin m_ph = 5; m_gen = m_seed; end
        default: if (step) begin m_gen = adv(m_gen); m_hi = 0; end
                 else if (rd) begin
                   m_data = m_hi ? (m_gen >> 8) & 'hFF : m_gen & 'hFF;
                   m_hi = 1 - m_hi;
                 end
      endcase
    end
  end

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    chk(busy == (m_ph != 5), "R7 busy", busy, m_ph != 5);
    chk(en == (m_ph != 5 && m_ph != 0), "R2/R7 enable", en, (m_ph != 5 && m_ph != 0));
    chk(rdata == m_data[7:0], "R9 read data", rdata, m_data);
  end

  task automatic do_reset();
    rst = 1; start = 0; valid = 0; stb = 0; step = 0; rd = 0;
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(busy && !en && rdata == 0, "R1 reset state", {busy, en, rdata}, 'h200);
  endtask

  task automatic feed(int v);
    samp = v[1:0]; stb = 1; @(negedge clk); stb = 0;
  endtask

  task automatic begin_collect();
    start = 1; @(negedge clk); start = 0;
    chk(en == 1, "R2 enable after start", en, 1);
    valid = 1; @(negedge clk);
  endtask

  task automatic rd_byte(output int b);
    rd = 1; @(negedge clk); rd = 0; b = rdata;
  endtask

  task automatic do_step();
    step = 1; @(negedge clk); step = 0;
  endtask

  task automatic wait_ready();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int b;
    @(negedge clk);
    cmp_on = 1;
    do_reset();

    // Case A: samples before valid ignored, ordinary seed 0x6C6D
    start = 1; @(negedge clk); start = 0;
    feed(3); feed(2); feed(1);
    rd = 1; @(negedge clk); rd = 0;
    chk(rdata == 0, "R9 read ignored while busy", rdata, 0);
    valid = 1; @(negedge clk);
    feed(1); feed(2); feed(3); feed(0); feed(1); feed(2); feed(3);
    chk(busy == 1, "R4 seven samples not enough", busy, 1);
    feed(1);
    wait_ready();
    chk(busy == 0 && en == 0, "R7 ready and source off", {busy, en}, 0);
    rd_byte(b); chk(b == 'h6D, "R3 R6 seed low byte", b, 'h6D);
    rd_byte(b); chk(b == 'h6C, "R6 seed high byte", b, 'h6C);
    do_step();
    rd_byte(b); chk(b == 'h37, "R8 one step low", b, 'h37);
    do_step();
    rd_byte(b); chk(b == 'h1A, "R9 odd read restarts low", b, 'h1A);
    rd_byte(b); chk(b == 'hEB, "R8 second step high", b, 'hEB);
    rd = 1; step = 1; @(negedge clk); rd = 0; step = 0;
    chk(rdata == 'hEB, "R9 read with step ignored", rdata, 'hEB);

    // Case B: eight zero samples give a forbidden 0x0000
    do_reset();
    begin_collect();
    for (int i = 0; i < 8; i++) feed(0);
    @(negedge clk);
    chk(busy == 1, "R5 zero seed rejected", busy, 1);
    feed(1);
    wait_ready();
    rd_byte(b); chk(b == 'h01, "R4 R5 saturated extra sample low", b, 'h01);
    rd_byte(b); chk(b == 'h00, "R5 extra sample high", b, 'h00);

    // Case C: eighth sample lands on 0x8003
    do_reset();
    begin_collect();
    feed(2); for (int i = 0; i < 6; i++) feed(0); feed(3);
    @(negedge clk);
    chk(busy == 1, "R5 0x8003 rejected", busy, 1);
    feed(0);
    wait_ready();
    rd_byte(b); chk(b == 'h0C, "R5 R3 continued seed low", b, 'h0C);
    rd_byte(b); chk(b == 'h00, "R5 continued seed high", b, 'h00);

    repeat (4) @(negedge clk);
    cmp_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 5000);
    cmp_on = 0;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected<5000", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule